// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is one timer channel for a memory-mapped peripheral. A 32-bit counter steps down once per divided tick and raises an interrupt flag each time it reaches zero. The base rate comes from a single-cycle `tick_en` input supplied by the surrounding clock logic. An internal prescaler passes that rate through unchanged, or divides it by 16 or by 256. Software controls the channel through a small register port: a word index, a write strobe and write data, plus combinational read data.

There are three counting modes. Free-running mode wraps to the all-ones value of the selected width (16 or 32 bits). Periodic mode wraps to a programmed reload value. One-shot mode counts down once and then parks at zero. The reload value can be replaced in two ways. An immediate load also restarts the count. A background load leaves the running count alone and applies at the next wrap. A raw flag records expiry. It drives the `irq` output and the masked status only while the interrupt-enable bit is set. The raw flag remains readable whether or not the interrupt is enabled.

The counter is governed by a three-state machine:
- `ST_IDLE`: the timer is disabled, so the count holds.
- `ST_COUNT`: the count moves on each divided tick.
- `ST_HALT`: a one-shot run has expired and the count is parked at zero.

Its transitions are:
- *enable*: a control write with the enable bit set moves `ST_IDLE` to `ST_COUNT`.
- *disable*: a control write with the enable bit clear moves any state to `ST_IDLE`.
- *expire*: a one-shot count reaching zero moves `ST_COUNT` to `ST_HALT`.
- *rearm*: a load write while enabled moves `ST_HALT` or `ST_IDLE` to `ST_COUNT`.
- *mode-release*: a control write that clears the one-shot bit while enabled moves `ST_HALT` to `ST_COUNT`.

Top module: `ivt_timer`

## Requirements
- R1: After reset, control reads 0x20 (interrupt enable only, timer disabled, 16-bit, free-running, divide by 1), the current value reads 0, raw and masked status read 0, and `irq` is low.
- R2: The word indices are: 0 immediate load, 1 current value, 2 control, 3 interrupt clear, 4 raw status (bit 0), 5 masked status (bit 0), 6 background load. Index 0 and index 6 both read back the reload value. Unused indices read 0.
- R3: Control field positions are: bit 7 enable, bit 6 periodic, bit 5 interrupt enable, bits 3:2 prescale select, bit 1 32-bit width, bit 0 one-shot. Bit 4 and bits above 7 read as 0.
- R4: In periodic mode (bit 6 set, bit 0 clear), each divided tick lowers the count by one. A tick that finds the count at zero reloads it from the reload value.
- R5: A write to index 0 sets the reload value and places the written value in the counter in the following cycle.
- R6: Writes to index 1 change nothing.
- R7: The raw flag is set in the cycle the count reaches zero on a tick. Any write to index 3 clears it.
- R8: `irq` and masked status both equal the raw flag gated by control bit 5, and they read 0 whenever bit 5 is clear.
- R9: With bits 6 and 0 both clear (free-running mode), a tick at zero reloads 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode.
- R10: A write to index 6 changes the reload value without touching the running count. The new value is used at the next wrap.
- R11: In one-shot mode, the count stops at zero after setting the raw flag and ignores further ticks until index 0 is written again.
- R12: In 16-bit mode, only the low 16 bits count and are compared with zero, and bits 31:16 of the current value read 0.
- R13: Prescale select 00 and 11 divide the tick by 1, 01 divides it by 16, and 10 divides it by 256. The divider phase restarts on every control write.
- R14: The count does not move in the cycle of a control write, nor while the enable bit is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Base-rate counting tick, one cycle per tick |
| bus_addr | input | 3 | Register word index |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt, raw flag gated by interrupt enable |

## Verification
Most state errors in this block reach the ports within one divided tick. A wrong state-machine state shows up on the next tick in one of two ways: the current value moves when it should hold, or it holds when it should move. A wrong reload or wrap target stays hidden until the count passes zero, and then appears as a wrong value read one tick later. For that reason, every mode is driven through at least one full wrap. A prescaler phase error appears only as a single tick arriving early or late at a divide boundary, so the count is read one tick before and one tick after each boundary.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
package ivt_pkg;

    // Register word indices
    localparam int IDX_LOAD   = 0;
    localparam int IDX_VALUE  = 1;
    localparam int IDX_CTRL   = 2;
    localparam int IDX_CLEAR  = 3;
    localparam int IDX_RAW    = 4;
    localparam int IDX_MASKED = 5;
    localparam int IDX_BGLOAD = 6;

    // Control bit positions
    localparam int B_ONESHOT  = 0;
    localparam int B_WIDE     = 1;
    localparam int B_PS_LO    = 2;
    localparam int B_PS_HI    = 3;
    localparam int B_IE       = 5;
    localparam int B_PERIODIC = 6;
    localparam int B_EN       = 7;

    typedef struct packed {
        logic       en;
        logic       periodic;
        logic       ie;
        logic [1:0] ps;
        logic       wide;
        logic       oneshot;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HALT  = 2'd2
    } cnt_state_e;

endpackage

// File: rtl/ivt_prescaler.sv
`timescale 1ns/1ps
module ivt_prescaler #(
    parameter int LOG_DIV_MID = 4,
    parameter int LOG_DIV_MAX = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic       tick_en,
    input  logic [1:0] sel,
    output logic       strobe
);
    localparam int PCW = LOG_DIV_MAX;
    localparam logic [PCW-1:0] MID_MASK = PCW'((1 << LOG_DIV_MID) - 1);

    logic [PCW-1:0] phase_q;
    logic [PCW-1:0] need;

    // Phase bits that must all be ones for a divided tick to pass
    always_comb begin
        unique case (sel)
            2'b01:   need = MID_MASK;
            2'b10:   need = '1;
            default: need = '0;
        endcase
    end

    assign strobe = run & tick_en & ((phase_q & need) == need);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (run && tick_en) begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/ivt_regs.sv
`timescale 1ns/1ps
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    input  logic [DATA_W-1:0] cur_value,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] reload_q,
    output logic              raw_q,
    output logic              load_wr,
    output logic              ctrl_wr,
    output logic [DATA_W-1:0] rdata
);
    logic              bg_wr;
    logic              clr_wr;
    logic [DATA_W-1:0] ctrl_word;

    assign load_wr = we && (idx == IDX_W'(IDX_LOAD));
    assign bg_wr   = we && (idx == IDX_W'(IDX_BGLOAD));
    assign ctrl_wr = we && (idx == IDX_W'(IDX_CTRL));
    assign clr_wr  = we && (idx == IDX_W'(IDX_CLEAR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '{ie: 1'b1, default: '0};
            reload_q  <= '0;
            raw_q     <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.en       <= wdata[B_EN];
                ctrl_q.periodic <= wdata[B_PERIODIC];
                ctrl_q.ie       <= wdata[B_IE];
                ctrl_q.ps       <= wdata[B_PS_HI:B_PS_LO];
                ctrl_q.wide     <= wdata[B_WIDE];
                ctrl_q.oneshot  <= wdata[B_ONESHOT];
            end
            if (load_wr || bg_wr) begin
                reload_q <= wdata;
            end
            // Expiry takes priority over a coincident clear
            if (expire) begin
                raw_q <= 1'b1;
            end else if (clr_wr) begin
                raw_q <= 1'b0;
            end
        end
    end

    always_comb begin
        ctrl_word                    = '0;
        ctrl_word[B_EN]              = ctrl_q.en;
        ctrl_word[B_PERIODIC]        = ctrl_q.periodic;
        ctrl_word[B_IE]              = ctrl_q.ie;
        ctrl_word[B_PS_HI:B_PS_LO]   = ctrl_q.ps;
        ctrl_word[B_WIDE]            = ctrl_q.wide;
        ctrl_word[B_ONESHOT]         = ctrl_q.oneshot;
    end

    always_comb begin
        rdata = '0;
        case (idx)
            IDX_W'(IDX_LOAD),
            IDX_W'(IDX_BGLOAD): rdata = reload_q;
            IDX_W'(IDX_VALUE):  rdata = cur_value;
            IDX_W'(IDX_CTRL):   rdata = ctrl_word;
            IDX_W'(IDX_RAW):    rdata = DATA_W'(raw_q);
            IDX_W'(IDX_MASKED): rdata = DATA_W'(raw_q & ctrl_q.ie);
            default:            rdata = '0;
        endcase
    end
endmodule

// File: rtl/ivt_counter.sv
`timescale 1ns/1ps
module ivt_counter
    import ivt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              periodic,
    input  logic              oneshot,
    input  logic              wide,
    input  logic [DATA_W-1:0] reload,
    input  logic              load_wr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              ctrl_wr,
    input  logic              new_en,
    input  logic              new_oneshot,
    input  logic              strobe,
    output logic [DATA_W-1:0] value,
    output logic              expire,
    output logic              run,
    output cnt_state_e        state
);
    localparam logic [DATA_W-1:0] NARROW_MASK =
        {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    cnt_state_e        state_n;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] cnt_n;
    logic [DATA_W-1:0] width_mask;
    logic [DATA_W-1:0] target;
    logic [DATA_W-1:0] cur;
    logic              free_run;

    assign width_mask = wide ? '1 : NARROW_MASK;
    assign free_run   = !periodic && !oneshot;
    assign target     = free_run ? width_mask : (reload & width_mask);
    assign cur        = cnt_q & width_mask;
    assign value      = cur;
    assign run        = (state == ST_COUNT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            state <= state_n;
            cnt_q <= cnt_n;
        end
    end

    // Next state and outputs
    always_comb begin
        state_n = state;
        cnt_n   = cnt_q;
        expire  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                state_n = state;
            end
            ST_COUNT: begin
                if (strobe) begin
                    if (oneshot) begin
                        if (cur <= DATA_W'(1)) begin
                            cnt_n   = '0;
                            expire  = 1'b1;
                            state_n = ST_HALT;
                        end else begin
                            cnt_n = cur - 1'b1;
                        end
                    end else if (cur == '0) begin
                        cnt_n  = target;
                        expire = (target == '0);
                    end else begin
                        cnt_n  = cur - 1'b1;
                        expire = (cur == DATA_W'(1));
                    end
                end
            end
            ST_HALT: begin
                state_n = state;
            end
            default: begin
                state_n = ST_IDLE;
            end
        endcase

        // Control write: pause this cycle, then apply the new mode
        if (ctrl_wr) begin
            cnt_n  = cnt_q;
            expire = 1'b0;
            if (!new_en) begin
                state_n = ST_IDLE;
            end else if (state == ST_HALT && new_oneshot) begin
                state_n = ST_HALT;
            end else begin
                state_n = ST_COUNT;
            end
        end else if (load_wr) begin
            cnt_n   = load_data;
            expire  = 1'b0;
            state_n = en ? ST_COUNT : ST_IDLE;
        end
    end
endmodule

// File: rtl/ivt_timer.sv
`timescale 1ns/1ps
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int NARROW_W    = 16,
    parameter int IDX_W       = 3,
    parameter int PS_LOG_MID  = 4,
    parameter int PS_LOG_MAX  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [IDX_W-1:0]  bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] reload_q;
    logic              raw_q;
    logic              load_wr;
    logic              ctrl_wr;
    logic              expire;
    logic              strobe;
    logic              run;
    logic [DATA_W-1:0] cur_value;
    cnt_state_e        cnt_state;

    ivt_regs #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .idx       (bus_addr),
        .wdata     (bus_wdata),
        .expire    (expire),
        .cur_value (cur_value),
        .ctrl_q    (ctrl_q),
        .reload_q  (reload_q),
        .raw_q     (raw_q),
        .load_wr   (load_wr),
        .ctrl_wr   (ctrl_wr),
        .rdata     (bus_rdata)
    );

    ivt_prescaler #(
        .LOG_DIV_MID (PS_LOG_MID),
        .LOG_DIV_MAX (PS_LOG_MAX)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctrl_wr),
        .run     (run),
        .tick_en (tick_en),
        .sel     (ctrl_q.ps),
        .strobe  (strobe)
    );

    ivt_counter #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (ctrl_q.en),
        .periodic    (ctrl_q.periodic),
        .oneshot     (ctrl_q.oneshot),
        .wide        (ctrl_q.wide),
        .reload      (reload_q),
        .load_wr     (load_wr),
        .load_data   (bus_wdata),
        .ctrl_wr     (ctrl_wr),
        .new_en      (bus_wdata[B_EN]),
        .new_oneshot (bus_wdata[B_ONESHOT]),
        .strobe      (strobe),
        .value       (cur_value),
        .expire      (expire),
        .run         (run),
        .state       (cnt_state)
    );

    assign irq = raw_q & ctrl_q.ie;
endmodule

// File: rtl/ivt_timer_chk.sv
`timescale 1ns/1ps
module ivt_timer_chk
    import ivt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int IDX_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic [IDX_W-1:0]  idx,
    input logic [DATA_W-1:0] wdata,
    input logic              irq,
    input logic              ie,
    input logic              en,
    input logic              wide,
    input logic              raw,
    input logic              strobe,
    input logic [DATA_W-1:0] value,
    input cnt_state_e        state
);
    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == IDX_W'(IDX_CLEAR) && !strobe) |=> !raw);

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq);

    assert_value_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == IDX_W'(IDX_VALUE) && !strobe) |=> $stable(value));

    assert_load_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == IDX_W'(IDX_LOAD)) |=>
        (value == (wide ? $past(wdata)
                        : {{(DATA_W-NARROW_W){1'b0}}, $past(wdata[NARROW_W-1:0])})));

    assert_narrow_upper_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> (value[DATA_W-1:NARROW_W] == '0));

    assert_halt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !we) |=> ($stable(value) && state == ST_HALT));

    assert_disabled_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !we) |=> $stable(value));
endmodule

bind ivt_timer ivt_timer_chk #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .IDX_W    (IDX_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (bus_we),
    .idx    (bus_addr),
    .wdata  (bus_wdata),
    .irq    (irq),
    .ie     (ctrl_q.ie),
    .en     (ctrl_q.en),
    .wide   (ctrl_q.wide),
    .raw    (raw_q),
    .strobe (strobe),
    .value  (cur_value),
    .state  (cnt_state)
);

// File: tb/ivt_timer_tb.sv
`timescale 1ns/1ps
module ivt_timer_tb;
    localparam int DW = 32;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [DW-1:0] exp_q[$];
    bit            kind_q[$];
    string         tag_q[$];

    always #2 clk = ~clk;

    ivt_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Driver tasks
    task automatic wr(input int idx, input logic [DW-1:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = AW'(idx);
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd_chk(input int idx, input logic [DW-1:0] e, input string tag);
        @(negedge clk);
        bus_addr = AW'(idx);
        exp_q.push_back(e);
        kind_q.push_back(1'b0);
        tag_q.push_back(tag);
    endtask

    task automatic irq_chk(input logic e, input string tag);
        @(negedge clk);
        exp_q.push_back(DW'(e));
        kind_q.push_back(1'b1);
        tag_q.push_back(tag);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Monitor: pops expected items and compares away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                logic [DW-1:0] e;
                logic [DW-1:0] a;
                bit            k;
                string         t;
                e = exp_q.pop_front();
                k = kind_q.pop_front();
                t = tag_q.pop_front();
                a = k ? DW'(irq) : bus_rdata;
                n_checks++;
                if (a !== e) begin
                    n_fails++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", t, a, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(2, 32'h20, "R1 control after reset");
        rd_chk(1, 32'h0,  "R1 value after reset");
        rd_chk(4, 32'h0,  "R1 raw after reset");
        rd_chk(5, 32'h0,  "R1 masked after reset");
        irq_chk(1'b0,     "R1 irq after reset");
        rd_chk(7, 32'h0,  "R2 unused index reads zero");

        // R4 R5 periodic 32-bit, divide by 1
        wr(0, 32'd5);
        rd_chk(1, 32'd5, "R5 load reaches counter");
        wr(2, 32'hE2);
        ticks(3);
        rd_chk(1, 32'd2, "R4 counts down");
        wr(1, 32'h1234);
        rd_chk(1, 32'd2, "R6 value write ignored");
        ticks(2);
        rd_chk(1, 32'd0, "R4 reaches zero");
        rd_chk(4, 32'd1, "R7 raw set at zero");
        rd_chk(5, 32'd1, "R8 masked follows raw");
        irq_chk(1'b1,    "R8 irq asserted");
        ticks(1);
        rd_chk(1, 32'd5, "R4 reload after zero");
        wr(3, 32'h0);
        rd_chk(4, 32'd0, "R7 clear drops raw");
        irq_chk(1'b0,    "R7 irq low after clear");

        // R10 background load
        wr(6, 32'd9);
        rd_chk(1, 32'd5, "R10 background load keeps count");
        rd_chk(0, 32'd9, "R2 load index reads reload");
        rd_chk(6, 32'd9, "R2 background index reads reload");
        ticks(5);
        rd_chk(1, 32'd0, "R10 old count expires");
        ticks(1);
        rd_chk(1, 32'd9, "R10 new reload at wrap");
        wr(3, 32'h0);

        // R8 masking, R14 hold during control write
        wr(2, 32'hC2);
        rd_chk(1, 32'd9, "R14 count held over control write");
        ticks(9);
        rd_chk(4, 32'd1, "R8 raw visible while masked");
        rd_chk(5, 32'd0, "R8 masked zero when disabled");
        irq_chk(1'b0,    "R8 irq low when masked");
        wr(2, 32'hE2);
        rd_chk(5, 32'd1, "R8 masked after unmask");
        irq_chk(1'b1,    "R8 irq after unmask");
        wr(3, 32'h0);

        // R9 R12 free-running 16-bit
        wr(2, 32'h80);
        ticks(1);
        rd_chk(1, 32'h0000FFFF, "R9 16-bit wrap target");
        ticks(2);
        rd_chk(1, 32'h0000FFFD, "R9 16-bit count");
        wr(0, 32'h12345678);
        rd_chk(1, 32'h00005678, "R12 upper bits read zero");
        ticks(1);
        rd_chk(1, 32'h00005677, "R12 low half counts");

        // R9 free-running 32-bit
        wr(2, 32'h82);
        wr(0, 32'd1);
        ticks(1);
        rd_chk(4, 32'd1, "R7 raw set in free-running");
        ticks(1);
        rd_chk(1, 32'hFFFFFFFF, "R9 32-bit wrap target");
        wr(3, 32'h0);

        // R11 one-shot
        wr(2, 32'hA3);
        wr(0, 32'd3);
        ticks(3);
        rd_chk(1, 32'd0, "R11 one-shot reaches zero");
        rd_chk(4, 32'd1, "R11 one-shot sets raw");
        ticks(4);
        rd_chk(1, 32'd0, "R11 one-shot stays at zero");
        wr(3, 32'h0);
        ticks(2);
        rd_chk(4, 32'd0, "R11 no further expiry");
        wr(0, 32'd2);
        ticks(1);
        rd_chk(1, 32'd1, "R11 reload restarts one-shot");

        // R13 prescaler
        wr(2, 32'hE6);
        wr(0, 32'd100);
        ticks(15);
        rd_chk(1, 32'd100, "R13 div16 before boundary");
        ticks(1);
        rd_chk(1, 32'd99,  "R13 div16 at boundary");
        ticks(32);
        rd_chk(1, 32'd97,  "R13 div16 two more");
        wr(2, 32'hEA);
        ticks(255);
        rd_chk(1, 32'd97,  "R13 div256 before boundary");
        ticks(1);
        rd_chk(1, 32'd96,  "R13 div256 at boundary");
        wr(2, 32'hEE);
        ticks(1);
        rd_chk(1, 32'd95,  "R13 select 11 divides by one");

        // R14 disabled hold
        wr(2, 32'h62);
        ticks(5);
        rd_chk(1, 32'd95, "R14 disabled count holds");
        rd_chk(2, 32'h62, "R3 control readback");

        // R3 undefined control bits
        wr(2, 32'hFFFFFFFF);
        rd_chk(2, 32'hEF, "R3 reserved bits read zero");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule